// File: doc/BRIEF.md
# Rename-Undo Reorder Buffer

This block keeps the program order of instructions that are in flight between decode and commit. It is a circular queue of entries. An entry is claimed when an instruction is decoded and given back when that instruction retires. An entry holds no result data. It holds the destination logical register, a done flag, and the virtual-physical tag that the destination was bound to before this instruction renamed it.

Retirement happens in order and only from the oldest entry, once its done flag is set. When speculation is discarded, a flush request names the oldest entry to throw away. The block then walks backwards from the youngest entry to that one, one entry per cycle. For each entry it shows the logical register and the saved tag, so the rename map can be restored step by step. The freed slots are reused by later decodes.

Top module: `rob_rollback`

## Requirements
- R1: After reset the buffer is empty, `full` is 0, `alloc_ready` is 1, `alloc_idx` is 0, and `commit_valid` and `rb_busy` are 0.
- R2: Each accepted allocation stores its logical register and previous tag in the slot shown on `alloc_idx`. `alloc_idx` then advances by one, modulo the depth (32 by default).
- R3: When all slots are in use and no commit is due, `full` is 1 and `alloc_ready` is 0. An allocation request in that state changes nothing.
- R4: `commit_valid` is 1 only when the oldest live entry is done. It shows that entry's logical register and previous tag, and that entry retires at the same edge. Entries retire strictly in allocation order. A completed younger entry never retires ahead of an older one that is not done.
- R5: A completion report marks its entry at the next clock edge. If that entry is the oldest, `commit_valid` is 1 in the following cycle.
- R6: When the buffer is full and a commit is due in the same cycle, `alloc_ready` is 1. Both the commit and the allocation take effect.
- R7: A flush on a non-empty buffer sets `rb_busy` from the next cycle. In each busy cycle the block shows the youngest remaining entry on `rb_lreg`/`rb_vp` and frees it, ending after the entry named by `flush_idx`. Afterwards `alloc_idx` equals `flush_idx`.
- R8: In the cycle a flush is requested, and in every busy cycle, `alloc_ready` and `commit_valid` are 0.
- R9: A flush request on an empty buffer is ignored. `rb_busy` stays 0 and `alloc_idx` does not change.
- R10: On a full buffer, a flush at the oldest entry's index rolls back all entries, one per cycle, and leaves the buffer empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode requests an entry |
| alloc_lreg | input | 5 | Destination logical register of the new entry |
| alloc_prev_vp | input | 7 | Tag the destination mapped to before this rename |
| alloc_ready | output | 1 | Allocation accepted this cycle if requested |
| alloc_idx | output | 5 | Slot the next allocation takes |
| done_valid | input | 1 | Completion report |
| done_idx | input | 5 | Slot that completed |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_lreg | output | 5 | Logical register of the retiring entry |
| commit_prev_vp | output | 7 | Saved tag of the retiring entry |
| flush_valid | input | 1 | Discard entries from youngest back to `flush_idx` |
| flush_idx | input | 5 | Oldest slot to discard |
| rb_busy | output | 1 | Rollback in progress; one entry shown per cycle |
| rb_lreg | output | 5 | Logical register of the entry being undone |
| rb_vp | output | 7 | Saved tag to restore for that register |
| full | output | 1 | All slots in use |
| empty | output | 1 | No slot in use |

## Verification
`alloc_ready` and `commit_valid` depend on the flush input in the same cycle, so the bench reads them just after it drives inputs. A completion becomes visible as a commit one cycle after its edge. Rollback output starts the cycle after the flush edge and takes one cycle per entry. The bench drives inputs 1 ns after a rising edge and samples 1 ns later, so each result is read in the cycle it is due and never on an edge. For the walks of several entries, the bench keeps its own per-slot record of what it allocated. It checks each rollback cycle's register and tag against that record, in the expected youngest-first order.

// File: rtl/rob_rollback.sv
module rob_rollback #(
  parameter int DEPTH  = 32,
  parameter int LREG_W = 5,
  parameter int VP_W   = 7,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [LREG_W-1:0] alloc_lreg,
  input  logic [VP_W-1:0]   alloc_prev_vp,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  output logic              commit_valid,
  output logic [LREG_W-1:0] commit_lreg,
  output logic [VP_W-1:0]   commit_prev_vp,
  input  logic              flush_valid,
  input  logic [IDX_W-1:0]  flush_idx,
  output logic              rb_busy,
  output logic [LREG_W-1:0] rb_lreg,
  output logic [VP_W-1:0]   rb_vp,
  output logic              full,
  output logic              empty
);

  logic [LREG_W-1:0] lreg_q [DEPTH];
  logic [VP_W-1:0]   vp_q   [DEPTH];
  logic [DEPTH-1:0]  done_q;
  logic [IDX_W-1:0]  head_q, tail_q, stop_q;
  logic [CNT_W-1:0]  count_q;
  logic              busy_q;

  logic [IDX_W-1:0]  last;
  logic              commit_fire, alloc_fire, flush_go;

  assign last        = tail_q - 1'b1;
  assign empty       = (count_q == '0);
  assign full        = (count_q == CNT_W'(DEPTH));
  assign commit_fire = !empty && done_q[head_q] && !busy_q && !flush_valid;
  assign flush_go    = flush_valid && !busy_q && !empty;
  assign alloc_ready = !busy_q && !flush_valid && (!full || commit_fire);
  assign alloc_fire  = alloc_valid && alloc_ready;

  assign alloc_idx      = tail_q;
  assign commit_valid   = commit_fire;
  assign commit_lreg    = lreg_q[head_q];
  assign commit_prev_vp = vp_q[head_q];
  assign rb_busy        = busy_q;
  assign rb_lreg        = lreg_q[last];
  assign rb_vp          = vp_q[last];

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      lreg_q[tail_q] <= alloc_lreg;
      vp_q[tail_q]   <= alloc_prev_vp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= '0;
    end else begin
      if (done_valid) done_q[done_idx] <= 1'b1;
      if (alloc_fire) done_q[tail_q]   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      stop_q  <= '0;
      count_q <= '0;
      busy_q  <= 1'b0;
    end else if (busy_q) begin
      tail_q  <= last;
      count_q <= count_q - 1'b1;
      if (last == stop_q) busy_q <= 1'b0;
    end else begin
      if (flush_go) begin
        stop_q <= flush_idx;
        busy_q <= 1'b1;
      end
      if (commit_fire) head_q <= head_q + 1'b1;
      if (alloc_fire)  tail_q <= tail_q + 1'b1;
      case ({alloc_fire, commit_fire})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/rob_rollback_chk.sv
module rob_rollback_chk #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             flush_valid,
  input logic             commit_valid,
  input logic             rb_busy,
  input logic             full,
  input logic             empty
);

  assert_idx_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |=> alloc_idx == IDX_W'($past(alloc_idx) + 1'b1));

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full && !commit_valid |-> !alloc_ready);

  assert_commit_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> !empty);

  assert_full_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full && commit_valid |-> alloc_ready);

  assert_rb_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rb_busy |=> alloc_idx == IDX_W'($past(alloc_idx) - 1'b1));

  assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_busy || flush_valid |-> !alloc_ready && !commit_valid);

  assert_empty_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && empty && !rb_busy |=> !rb_busy);

endmodule

bind rob_rollback rob_rollback_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_idx(alloc_idx), .flush_valid(flush_valid), .commit_valid(commit_valid),
  .rb_busy(rb_busy), .full(full), .empty(empty)
);

// File: tb/tb_rob_rollback.sv
`timescale 1ns/100ps
module tb_rob_rollback;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 1'b0;
  logic [4:0] alloc_lreg = '0;
  logic [6:0] alloc_prev_vp = '0;
  logic       alloc_ready;
  logic [4:0] alloc_idx;
  logic       done_valid = 1'b0;
  logic [4:0] done_idx = '0;
  logic       commit_valid;
  logic [4:0] commit_lreg;
  logic [6:0] commit_prev_vp;
  logic       flush_valid = 1'b0;
  logic [4:0] flush_idx = '0;
  logic       rb_busy;
  logic [4:0] rb_lreg;
  logic [6:0] rb_vp;
  logic       full, empty;

  int checks = 0;
  int errors = 0;
  logic [4:0] m_lreg [32];
  logic [6:0] m_vp   [32];

  localparam logic [11:0] VEC [8] = '{
    {5'd3, 7'd17}, {5'd9, 7'd100}, {5'd3, 7'd5}, {5'd31, 7'd0},
    {5'd0, 7'd127}, {5'd12, 7'd64}, {5'd7, 7'd33}, {5'd12, 7'd90}
  };

  always #2 clk = ~clk;

  rob_rollback dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_lreg(alloc_lreg), .alloc_prev_vp(alloc_prev_vp),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .done_valid(done_valid), .done_idx(done_idx),
    .commit_valid(commit_valid), .commit_lreg(commit_lreg), .commit_prev_vp(commit_prev_vp),
    .flush_valid(flush_valid), .flush_idx(flush_idx),
    .rb_busy(rb_busy), .rb_lreg(rb_lreg), .rb_vp(rb_vp),
    .full(full), .empty(empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic commit_is(input string req, input int slot);
    chk({req, " commit_valid"}, commit_valid, 1);
    chk({req, " commit_lreg"}, commit_lreg, m_lreg[slot]);
    chk({req, " commit_prev_vp"}, commit_prev_vp, m_vp[slot]);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 commit_valid", commit_valid, 0);
    chk("R1 rb_busy", rb_busy, 0);
    step();

    for (int i = 0; i < 8; i++) begin
      alloc_valid = 1'b1;
      {alloc_lreg, alloc_prev_vp} = VEC[i];
      m_lreg[i] = VEC[i][11:7];
      m_vp[i] = VEC[i][6:0];
      #1;
      chk("R2 alloc_idx", alloc_idx, i);
      chk("R4 no commit before done", commit_valid, 0);
      step();
    end
    alloc_valid = 1'b0;

    done_valid = 1'b1; done_idx = 5'd3; step();
    done_idx = 5'd1; step();
    done_valid = 1'b0; #1;
    chk("R4 younger done no commit", commit_valid, 0);
    done_valid = 1'b1; done_idx = 5'd0; #1;
    chk("R5 not before edge", commit_valid, 0);
    step();
    done_valid = 1'b0; #1;
    commit_is("R5", 0);
    step(); #1;
    commit_is("R4 order", 1);
    step(); #1;
    chk("R4 head not done", commit_valid, 0);
    done_valid = 1'b1; done_idx = 5'd2; step();
    done_valid = 1'b0; #1;
    commit_is("R4", 2);
    step(); #1;
    commit_is("R4", 3);
    step(); #1;
    chk("R4 head 4 waits", commit_valid, 0);

    flush_valid = 1'b1; flush_idx = 5'd5; #1;
    chk("R8 flush cycle alloc_ready", alloc_ready, 0);
    chk("R8 flush cycle commit", commit_valid, 0);
    step();
    flush_valid = 1'b0;
    for (int k = 7; k >= 5; k--) begin
      #1;
      chk("R7 rb_busy", rb_busy, 1);
      chk("R7 rb_lreg", rb_lreg, m_lreg[k]);
      chk("R7 rb_vp", rb_vp, m_vp[k]);
      chk("R8 busy alloc_ready", alloc_ready, 0);
      step();
    end
    #1;
    chk("R7 busy ends", rb_busy, 0);
    chk("R7 alloc_idx", alloc_idx, 5);
    chk("R7 older entry kept", empty, 0);

    done_valid = 1'b1; done_idx = 5'd4; step();
    done_valid = 1'b0; #1;
    commit_is("R4", 4);
    step(); #1;
    chk("R9 empty", empty, 1);
    flush_valid = 1'b1; flush_idx = 5'd3; step();
    flush_valid = 1'b0; #1;
    chk("R9 rb_busy", rb_busy, 0);
    chk("R9 alloc_idx", alloc_idx, 5);
    chk("R9 alloc_ready", alloc_ready, 1);

    for (int k = 0; k < 32; k++) begin
      alloc_valid = 1'b1;
      alloc_lreg = 5'(k);
      alloc_prev_vp = 7'(k + 40);
      m_lreg[(5 + k) % 32] = 5'(k);
      m_vp[(5 + k) % 32] = 7'(k + 40);
      step();
    end
    alloc_valid = 1'b0; #1;
    chk("R3 full", full, 1);
    chk("R3 alloc_ready", alloc_ready, 0);
    alloc_valid = 1'b1; alloc_lreg = 5'd9; alloc_prev_vp = 7'd9; step();
    alloc_valid = 1'b0; #1;
    chk("R3 ignored alloc_idx", alloc_idx, 5);
    chk("R3 still full", full, 1);

    done_valid = 1'b1; done_idx = 5'd5; step();
    done_valid = 1'b0;
    alloc_valid = 1'b1; alloc_lreg = 5'd31; alloc_prev_vp = 7'd99; #1;
    commit_is("R6", 5);
    chk("R6 alloc_ready", alloc_ready, 1);
    m_lreg[5] = 5'd31; m_vp[5] = 7'd99;
    step();
    alloc_valid = 1'b0; #1;
    chk("R6 full after", full, 1);
    chk("R6 alloc_idx", alloc_idx, 6);

    flush_valid = 1'b1; flush_idx = 5'd6; step();
    flush_valid = 1'b0;
    for (int k = 0; k < 32; k++) begin
      #1;
      chk("R10 rb_busy", rb_busy, 1);
      chk("R10 rb_lreg", rb_lreg, m_lreg[(5 - k) & 31]);
      chk("R10 rb_vp", rb_vp, m_vp[(5 - k) & 31]);
      step();
    end
    #1;
    chk("R10 busy ends", rb_busy, 0);
    chk("R10 empty", empty, 1);
    chk("R10 alloc_idx", alloc_idx, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule